// File: doc/BRIEF.md
# External Bus Ownership Arbiter

This block decides which of three masters drives a shared external bus. The masters are the processor (the default owner), a DMA engine that moves data only over the external bus, and an off-chip device that requests the bus through an active-low pin. Exactly one owner holds the bus at a time. Every change of owner passes through one clock in which nobody holds it. Grants are decoded from a single owner register, and a synchronous reset returns that register to the idle state. The reset input also masks every grant in the same cycle, so an access in progress is dropped at once.

The DMA owner gives the bus back according to its transfer mode. In normal or cycle-steal mode it releases after every single transfer. In block mode it releases after each complete block. In burst mode it holds the bus until the whole transfer is finished. An optional yield flag lets a block- or burst-mode owner step aside when the processor wants an external access. The DMA engine then gets the bus back once that access ends. An off-chip request counts only while the release-enable input is set. It is served only when the current owner reaches the end of its bus cycle, and the acknowledge output follows the off-chip ownership.

Top module: `xbus_arbiter`

## Requirements
- R1: While `rst` is 1, all three grants and `rel_ack` are 0 in that same cycle, whatever was owned before. After `rst` falls, the first clock edge grants the bus by the priority of R3.
- R2: At most one grant is 1 at any time. Between two different owners there is at least one clock in which all grants are 0.
- R3: From the idle state the next owner is chosen in a fixed order: the qualified off-chip request first, then `dma_req`, then the processor. The processor is granted when nothing is requested.
- R4: While `ext_rel_en` is 0, a low `ext_req_n` has no effect: the off-chip device is never granted, and the processor keeps the bus.
- R5: While `cpu_req` is 1, a processor owner keeps the bus until `cyc_done` is 1. A DMA owner whose `dma_req` is 1 also keeps the bus until `cyc_done` is 1. A processor owner with `cpu_req` at 0 has no cycle open and gives way at once to any other request.
- R6: With `dma_mode` at 0 (normal) or 1 (cycle steal), the DMA owner releases on a clock where `cyc_done` and `dma_beat_done` are both 1. Without a beat it keeps the bus.
- R7: With `dma_mode` at 2 (block), only `dma_block_done` together with `cyc_done` releases the DMA owner. A beat alone does not.
- R8: With `dma_mode` at 3 (burst), only `dma_xfer_done` together with `cyc_done` releases the DMA owner. Beat and block strobes do not.
- R9: In block or burst mode, with `dma_yield` at 1, a `cyc_done` while `cpu_req` is 1 releases the DMA owner, and the processor is granted next. With `dma_yield` at 0, or in modes 0 and 1, `cpu_req` does not cause a release.
- R10: After the DMA owner releases, if `cpu_req` is 1 at the next pick, the processor is granted ahead of the DMA engine for one tenure. If `cpu_req` is 0, the DMA engine is granted directly.
- R11: `rel_ack` is 1 exactly while the off-chip device owns the bus. On the first edge that samples `ext_req_n` high, or `ext_rel_en` low, the ownership and `rel_ack` end. The next edge grants by R3.
- R12: A DMA owner whose `dma_req` falls gives up the bus on the next edge, without waiting for `cyc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also masks grants at once |
| cpu_req | input | 1 | Processor has an external access pending |
| dma_req | input | 1 | DMA engine has an activation pending |
| dma_mode | input | 2 | 0 normal, 1 cycle steal, 2 block, 3 burst |
| dma_yield | input | 1 | Let a block/burst DMA owner yield to the processor |
| dma_beat_done | input | 1 | Strobe: one DMA transfer finished |
| dma_block_done | input | 1 | Strobe: one DMA block finished |
| dma_xfer_done | input | 1 | Strobe: the whole DMA transfer finished |
| cyc_done | input | 1 | Strobe: the current external bus cycle ends this clock |
| ext_req_n | input | 1 | Off-chip bus request, active low |
| ext_rel_en | input | 1 | Enables off-chip requests |
| gnt_cpu | output | 1 | Processor owns the bus |
| gnt_dma | output | 1 | DMA engine owns the bus |
| gnt_ext | output | 1 | Off-chip device owns the bus |
| rel_ack | output | 1 | Bus released to the off-chip device |

## Verification
Each DMA mode is run against every strobe that should not release it and then against the one that should. This separates a mode that releases too early from one that never releases. The processor's cycle is held open across competing requests, which shows whether a handover waits for `cyc_done`. The off-chip request is raised with the enable low and then high, which shows whether the enable gates the request. A yield is tried with the flag clear, with the flag set in normal mode, and with it set in block and burst modes. Combined with pending and absent processor requests, this shows whether the processor is favoured once and only when it asks. A reset asserted during off-chip ownership checks that the grants drop before any clock edge.

// File: rtl/xbus_arb_pkg.sv
package xbus_arb_pkg;

    localparam int MODE_W  = 2;
    localparam int OWNER_W = 2;

    typedef enum logic [MODE_W-1:0] {
        DM_NORMAL = 2'd0,
        DM_STEAL  = 2'd1,
        DM_BLOCK  = 2'd2,
        DM_BURST  = 2'd3
    } dma_mode_e;

    typedef enum logic [OWNER_W-1:0] {
        OWN_IDLE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_DMA  = 2'd2,
        OWN_EXT  = 2'd3
    } owner_e;

    typedef struct packed {
        logic beat;
        logic block;
        logic xfer;
    } dma_evt_t;

    typedef struct packed {
        logic ext;
        logic dma;
        logic cpu;
    } req_vec_t;

    // True when the strobe that ends a tenure in this mode is present
    function automatic logic end_reached(dma_mode_e m, dma_evt_t e);
        case (m)
            DM_NORMAL, DM_STEAL: return e.beat;
            DM_BLOCK:            return e.block;
            default:             return e.xfer;
        endcase
    endfunction

    // Only the long-tenure modes may step aside for the processor
    function automatic logic may_yield(dma_mode_e m);
        return (m == DM_BLOCK) || (m == DM_BURST);
    endfunction

endpackage

// File: rtl/xbus_ext_qual.sv
module xbus_ext_qual (
    input  logic req_n,
    input  logic enable,
    output logic active
);
    // Off-chip request counts only while enabled
    assign active = enable & ~req_n;
endmodule

// File: rtl/xbus_dma_policy.sv
module xbus_dma_policy
    import xbus_arb_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  dma_evt_t          evt,
    input  logic              yield_en,
    input  logic              cpu_pending,
    input  logic              cyc_done,
    input  logic              dma_req,
    output logic              release_o
);
    dma_mode_e m;
    logic      end_hit;
    logic      yield_hit;

    assign m = dma_mode_e'(mode);

    always_comb begin
        end_hit   = end_reached(m, evt);
        yield_hit = yield_en & cpu_pending & may_yield(m);
        // A withdrawn request frees the bus; otherwise wait for a cycle boundary
        release_o = ~dma_req | (cyc_done & (end_hit | yield_hit));
    end
endmodule

// File: rtl/xbus_owner_fsm.sv
module xbus_owner_fsm
    import xbus_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  req_vec_t req,
    input  logic     cyc_done,
    input  logic     dma_release,
    output owner_e   owner_o
);
    owner_e own_q, own_d;
    logic   turn_q, turn_d;

    always_comb begin
        own_d  = own_q;
        turn_d = turn_q;
        unique case (own_q)
            OWN_IDLE: begin
                if (req.ext)
                    own_d = OWN_EXT;
                else if (req.dma && !(turn_q && req.cpu))
                    own_d = OWN_DMA;
                else
                    own_d = OWN_CPU;
                if (own_d != OWN_EXT)
                    turn_d = 1'b0;
            end
            OWN_CPU: begin
                if ((req.ext || req.dma) && (cyc_done || !req.cpu))
                    own_d = OWN_IDLE;
            end
            OWN_DMA: begin
                if (dma_release) begin
                    own_d  = OWN_IDLE;
                    turn_d = 1'b1;
                end
            end
            OWN_EXT: begin
                if (!req.ext)
                    own_d = OWN_IDLE;
            end
            default: own_d = OWN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= OWN_IDLE;
            turn_q <= 1'b0;
        end else begin
            own_q  <= own_d;
            turn_q <= turn_d;
        end
    end

    assign owner_o = own_q;

    // R10
    turn_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_IDLE && turn_q && req.cpu && !req.ext) |=> (own_q == OWN_CPU));

    // R2
    idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (own_q != OWN_IDLE && own_q != $past(own_q)) |-> ($past(own_q) == OWN_IDLE));
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
    import xbus_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              dma_req,
    input  logic [MODE_W-1:0] dma_mode,
    input  logic              dma_yield,
    input  logic              dma_beat_done,
    input  logic              dma_block_done,
    input  logic              dma_xfer_done,
    input  logic              cyc_done,
    input  logic              ext_req_n,
    input  logic              ext_rel_en,
    output logic              gnt_cpu,
    output logic              gnt_dma,
    output logic              gnt_ext,
    output logic              rel_ack
);
    logic     ext_active;
    logic     dma_rel;
    req_vec_t req;
    dma_evt_t evt;
    owner_e   owner;

    assign evt = '{beat: dma_beat_done, block: dma_block_done, xfer: dma_xfer_done};
    assign req = '{ext: ext_active, dma: dma_req, cpu: cpu_req};

    xbus_ext_qual u_qual (
        .req_n  (ext_req_n),
        .enable (ext_rel_en),
        .active (ext_active)
    );

    xbus_dma_policy u_policy (
        .mode        (dma_mode),
        .evt         (evt),
        .yield_en    (dma_yield),
        .cpu_pending (cpu_req),
        .cyc_done    (cyc_done),
        .dma_req     (dma_req),
        .release_o   (dma_rel)
    );

    xbus_owner_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .cyc_done    (cyc_done),
        .dma_release (dma_rel),
        .owner_o     (owner)
    );

    // Reset masks every grant in the same cycle
    always_comb begin
        gnt_cpu = !rst && (owner == OWN_CPU);
        gnt_dma = !rst && (owner == OWN_DMA);
        gnt_ext = !rst && (owner == OWN_EXT);
        rel_ack = !rst && (owner == OWN_EXT);
    end

    // R1
    always_comb begin
        if (rst) begin
            rst_quiet_chk: assert (!gnt_cpu && !gnt_dma && !gnt_ext && !rel_ack);
        end
    end

    // R2
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(gnt_cpu) || $rose(gnt_dma) || $rose(gnt_ext)) |-> $past(!(gnt_cpu || gnt_dma || gnt_ext)));

    // R4
    ext_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_rel_en && !gnt_ext) |=> !gnt_ext);

    // R5
    cpu_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_cpu && cpu_req && !cyc_done) |=> gnt_cpu);

    // R5
    dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_dma && dma_req && !cyc_done) |=> gnt_dma);

    // R6
    single_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_dma && dma_req && dma_mode[1] == 1'b0 && !dma_beat_done) |=> gnt_dma);

    // R8
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_dma && dma_req && dma_mode == 2'd3 && !dma_xfer_done && !(dma_yield && cpu_req))
        |=> gnt_dma);

    // R11
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_ext && (ext_req_n || !ext_rel_en)) |=> !rel_ack);
endmodule

// File: tb/xbus_arbiter_test.sv
`timescale 1ns/1ps
module xbus_arbiter_test;
    localparam logic [3:0] E_NONE = 4'b0000;
    localparam logic [3:0] E_CPU  = 4'b0001;
    localparam logic [3:0] E_DMA  = 4'b0010;
    localparam logic [3:0] E_EXT  = 4'b1100;

    logic       clk = 1'b0;
    logic       rst, cpu_req, dma_req, dma_yield;
    logic [1:0] dma_mode;
    logic       beat, blk, xfer, cyc_done, ext_req_n, ext_rel_en;
    logic       gnt_cpu, gnt_dma, gnt_ext, rel_ack;
    logic [3:0] obs;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    xbus_arbiter uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .dma_req(dma_req),
        .dma_mode(dma_mode), .dma_yield(dma_yield), .dma_beat_done(beat),
        .dma_block_done(blk), .dma_xfer_done(xfer), .cyc_done(cyc_done),
        .ext_req_n(ext_req_n), .ext_rel_en(ext_rel_en),
        .gnt_cpu(gnt_cpu), .gnt_dma(gnt_dma), .gnt_ext(gnt_ext), .rel_ack(rel_ack)
    );

    assign obs = {rel_ack, gnt_ext, gnt_dma, gnt_cpu};

    // Monitor: compare the outputs after each edge with the queued expectation
    always @(posedge clk) begin
        item_t it;
        #1;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (obs !== it.exp) begin
                fails++;
                $display("FAIL %s: got %b expected %b", it.tag, obs, it.exp);
            end
        end
    end

    // Driver: queue the expectation for the coming edge, then clear strobes
    task automatic cyc(input logic [3:0] e, input string t);
        item_t it;
        it.exp = e;
        it.tag = t;
        sb.push_back(it);
        @(negedge clk);
        cyc_done = 1'b0; beat = 1'b0; blk = 1'b0; xfer = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; cpu_req = 1'b0; dma_req = 1'b0; dma_yield = 1'b0; dma_mode = 2'd0;
        beat = 1'b0; blk = 1'b0; xfer = 1'b0; cyc_done = 1'b0;
        ext_req_n = 1'b1; ext_rel_en = 1'b0;
        @(negedge clk);
        cyc(E_NONE, "R1"); cyc(E_NONE, "R1");
        rst = 1'b0;
        cyc(E_CPU, "R1"); cyc(E_CPU, "R3");
        // R4: request pin low while disabled
        ext_req_n = 1'b0;
        cyc(E_CPU, "R4"); cyc(E_CPU, "R4");
        ext_rel_en = 1'b1;
        cyc(E_NONE, "R2"); cyc(E_EXT, "R3"); cyc(E_EXT, "R11");
        ext_req_n = 1'b1;
        cyc(E_NONE, "R11"); cyc(E_CPU, "R11");
        // R5: processor cycle held open against off-chip request
        cpu_req = 1'b1; ext_req_n = 1'b0;
        cyc(E_CPU, "R5"); cyc(E_CPU, "R5");
        cyc_done = 1'b1; cyc(E_NONE, "R5"); cyc(E_EXT, "R3");
        ext_req_n = 1'b1;
        cyc(E_NONE, "R11"); cyc(E_CPU, "R3");
        // R3: off-chip beats DMA beats processor
        dma_req = 1'b1; ext_req_n = 1'b0; cyc_done = 1'b1;
        cyc(E_NONE, "R2"); cyc(E_EXT, "R3");
        ext_req_n = 1'b1;
        cyc(E_NONE, "R11"); cyc(E_DMA, "R3");
        // R6: normal mode
        dma_mode = 2'd0; cyc_done = 1'b1; cyc(E_DMA, "R6");
        cyc_done = 1'b1; beat = 1'b1; cyc(E_NONE, "R6");
        cyc(E_CPU, "R10"); cyc(E_CPU, "R5");
        cyc_done = 1'b1; cyc(E_NONE, "R10"); cyc(E_DMA, "R10");
        // cycle steal mode
        dma_mode = 2'd1; beat = 1'b1; cyc(E_DMA, "R5");
        cyc_done = 1'b1; beat = 1'b1; cyc(E_NONE, "R6");
        cpu_req = 1'b0; cyc(E_DMA, "R10");
        // R7: block mode
        dma_mode = 2'd2; cyc_done = 1'b1; beat = 1'b1; cyc(E_DMA, "R7");
        cyc_done = 1'b1; blk = 1'b1; cyc(E_NONE, "R7"); cyc(E_DMA, "R7");
        // R8: burst mode
        dma_mode = 2'd3; cyc_done = 1'b1; blk = 1'b1; cyc(E_DMA, "R8");
        cyc_done = 1'b1; beat = 1'b1; cyc(E_DMA, "R8");
        cyc_done = 1'b1; xfer = 1'b1; cyc(E_NONE, "R8"); cyc(E_DMA, "R8");
        // R9: yield flag
        cpu_req = 1'b1; dma_yield = 1'b0; cyc_done = 1'b1; cyc(E_DMA, "R9");
        dma_yield = 1'b1; cyc(E_DMA, "R5");
        cyc_done = 1'b1; cyc(E_NONE, "R9"); cyc(E_CPU, "R9");
        cyc_done = 1'b1; cyc(E_NONE, "R9"); cyc(E_DMA, "R9");
        dma_mode = 2'd0; cyc_done = 1'b1; cyc(E_DMA, "R9");
        dma_mode = 2'd2; cyc_done = 1'b1; cyc(E_NONE, "R9"); cyc(E_CPU, "R9");
        cpu_req = 1'b0; cyc(E_NONE, "R10"); cyc(E_DMA, "R10");
        // R12: request withdrawn mid tenure
        dma_yield = 1'b0; dma_req = 1'b0;
        cyc(E_NONE, "R12"); cyc(E_CPU, "R12");
        // R1: reset during off-chip ownership
        ext_req_n = 1'b0;
        cyc(E_NONE, "R2"); cyc(E_EXT, "R3");
        rst = 1'b1;
        #1;
        checks++;
        if (obs !== E_NONE) begin
            fails++;
            $display("FAIL R1: got %b expected %b", obs, E_NONE);
        end
        cyc(E_NONE, "R1");
        rst = 1'b0;
        cyc(E_EXT, "R1");
        ext_req_n = 1'b1;
        cyc(E_NONE, "R11"); cyc(E_CPU, "R11");
        repeat (2) @(negedge clk);
        summary();
    end
endmodule